// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block is the fetch front end of a small processor. Its instruction words are 16 bits wide and sit in byte-addressed program memory. It keeps a 21-bit byte program counter and asks a synchronous word-read memory for one word per cycle. It sorts each returned word into one of four classes: a plain single word, the head of a two-word instruction, a tail word with the prefix 1111, or a relative branch. The result goes out as a registered instruction event. An event is a real instruction, or a NOP with the byte address of the word it replaced.

A two-word instruction is passed downstream only once both words have arrived. The two 12-bit payload fields are then joined into one operand. Absolute jumps, calls and taken relative branches redirect the counter, and the word already in flight is dropped as one NOP bubble. An execute stage can pulse `skip_req` to throw away the next word. A tail word reached this way, without its head, turns into a harmless NOP.

Top module: `insn_fetch_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0 and `mem_addr` is 0. Reset clears every held word and any pending skip.
- R2: The program counter is a byte address with bit 0 always 0. `mem_addr` carries counter bits 20..1, and the counter steps by 2 for each word fetched. `out_pc` reports the even byte address of an event's first word.
- R3: A single word whose top nibble is none of 0xC, 0xF, 0xE with bits 11..10 = 11, or 0xD with bit 11 = 0 gives one event the cycle after it returns: `out_valid`=1, `out_nop`=0, `out_two`=0, and `out_instr` equal to the word.
- R4: Heads of two-word instructions are 0xC??? (register move), 0xEC??/0xED?? (call), 0xEE?? (load pointer) and 0xEF?? (goto). A head gives no event. The word after it completes the instruction with `out_two`=1, `out_instr`=head, `out_opnd`={head[11:0], second[11:0]}, and `out_pc` equal to the head's address.
- R5: A word with top nibble 0xF that is not completing a head gives a NOP event at its own address.
- R6: A completed goto or call sends the counter to byte address {second[11:0], head[7:0], 0}. For example, 0xEF03 followed by 0xF000 goes to 0x000006.
- R7: A word with bits 15..11 = 11010 is a relative branch with a signed 11-bit word offset in bits 10..0. Its target is the branch address + 2 + 2×offset.
- R8: After every redirect there is exactly one NOP bubble, carrying the address of the word that was dropped. The next event comes from the target.
- R9: `skip_req` throws away exactly one word as a NOP event. It takes the word returned in the same cycle, unless that word is a dropped bubble or the second half of a held head; in that case it waits for the next word that starts an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| skip_req | input | 1 | Throw away the next instruction-starting word |
| mem_addr | output | 20 | Word address sent to program memory |
| mem_rdata | input | 16 | Word read from memory, one cycle after its address |
| out_valid | output | 1 | An instruction event is present |
| out_nop | output | 1 | The event is a NOP (bubble, skipped word or lone tail) |
| out_two | output | 1 | The event is a completed two-word instruction |
| out_instr | output | 16 | First word of the instruction |
| out_opnd | output | 24 | Joined payloads of a two-word instruction |
| out_pc | output | 21 | Byte address of the event's first word |

## Verification
The bench builds the block with its default 21-bit counter and a 256-word memory model. The program in that memory reaches every word class, both branch directions, calls and gotos (one of them the 0xEF03/0xF000 case), lone tails, and skips that land on the head of a pair. It also sends a skip during a bubble cycle so that the skip has to wait. An arithmetic walker in the bench works out the expected event stream from the memory image, including the joined operands, the computed targets and the bubble addresses. That stream is compared event by event over repeated passes of the program loop, and again after a reset in the middle of the run.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  localparam int WORD_W = 16;
  localparam int PAY_W  = 12;
  localparam int OFF_W  = 11;

  typedef enum logic [1:0] {
    WC_SINGLE,
    WC_HEAD,
    WC_TAIL,
    WC_BRANCH
  } wclass_e;

  // Tail words carry payload only; alone they are harmless.
  function automatic logic is_tail(input logic [WORD_W-1:0] w);
    return w[15:12] == 4'hF;
  endfunction

  // Goto (0xEF) and call (0xEC/0xED) move the counter.
  function automatic logic is_abs_jump(input logic [WORD_W-1:0] w);
    return (w[15:8] == 8'hEF) || (w[15:9] == 7'b1110110);
  endfunction

  // Heads of pairs: register move, load pointer, and the two jumps.
  function automatic logic is_pair_head(input logic [WORD_W-1:0] w);
    return (w[15:12] == 4'hC) || (w[15:8] == 8'hEE) || is_abs_jump(w);
  endfunction

  function automatic logic is_rel_branch(input logic [WORD_W-1:0] w);
    return w[15:11] == 5'b11010;
  endfunction

  function automatic wclass_e classify(input logic [WORD_W-1:0] w);
    if (is_tail(w))            return WC_TAIL;
    else if (is_pair_head(w))  return WC_HEAD;
    else if (is_rel_branch(w)) return WC_BRANCH;
    else                       return WC_SINGLE;
  endfunction

endpackage

// File: rtl/fseq_decode.sv
module fseq_decode
  import fseq_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output wclass_e           cls
);

  always_comb cls = classify(word);

endmodule

// File: rtl/fseq_pc.sv
module fseq_pc #(
  parameter int PC_W = 21
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            redir,
  input  logic [PC_W-1:0] redir_pc,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] fpc_q,
  output logic            req_vld_q,
  output logic            flush_q
);

  function automatic logic [PC_W-1:0] next_word(input logic [PC_W-1:0] p);
    return p + PC_W'(2);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      fpc_q     <= '0;
      req_vld_q <= 1'b0;
      flush_q   <= 1'b0;
    end else begin
      fpc_q     <= pc_q;
      req_vld_q <= 1'b1;
      flush_q   <= redir;
      pc_q      <= redir ? {redir_pc[PC_W-1:1], 1'b0} : next_word(pc_q);
    end
  end

  // R2: sequential fetch advances one word.
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    !redir |=> pc_q == $past(pc_q) + PC_W'(2));

  // R6, R7: a redirect lands on the requested target.
  assert_land_R6: assert property (@(posedge clk) disable iff (rst)
    redir |=> pc_q == $past(redir_pc));

endmodule

// File: rtl/fseq_join.sv
module fseq_join
  import fseq_pkg::*;
#(
  parameter int PC_W = 21,
  localparam int OPND_W = 2 * PAY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic              flush,
  input  logic [PC_W-1:0]   fpc,
  input  logic [WORD_W-1:0] word,
  input  wclass_e           cls,
  input  logic              skip_req,
  output logic              redir,
  output logic [PC_W-1:0]   redir_pc,
  output logic              out_valid,
  output logic              out_nop,
  output logic              out_two,
  output logic [WORD_W-1:0] out_instr,
  output logic [OPND_W-1:0] out_opnd,
  output logic [PC_W-1:0]   out_pc
);

  function automatic logic [PC_W-1:0] abs_target(input logic [WORD_W-1:0] head,
                                                  input logic [WORD_W-1:0] tail);
    logic [20:0] t;
    t = {tail[PAY_W-1:0], head[7:0], 1'b0};
    return PC_W'(t);
  endfunction

  function automatic logic [PC_W-1:0] rel_target(input logic [PC_W-1:0] at,
                                                  input logic [WORD_W-1:0] w);
    logic [PC_W-1:0] step;
    step = {{(PC_W-OFF_W-1){w[OFF_W-1]}}, w[OFF_W-1:0], 1'b0};
    return at + PC_W'(2) + step;
  endfunction

  logic              hold_q;
  logic [WORD_W-1:0] head_q;
  logic [PC_W-1:0]   head_pc_q;
  logic              skip_pend_q;

  // Named events for the assertions.
  logic eligible, skip_hit;
  logic evt_bubble, evt_join, evt_orphan, evt_hold, evt_branch, evt_single;

  always_comb begin
    eligible   = req_vld && !flush && !hold_q;
    skip_hit   = eligible && (skip_req || skip_pend_q);
    evt_bubble = req_vld && flush;
    evt_join   = req_vld && !flush && hold_q;
    evt_orphan = eligible && !skip_hit && (cls == WC_TAIL);
    evt_hold   = eligible && !skip_hit && (cls == WC_HEAD);
    evt_branch = eligible && !skip_hit && (cls == WC_BRANCH);
    evt_single = eligible && !skip_hit && (cls == WC_SINGLE);
    redir      = (evt_join && is_abs_jump(head_q)) || evt_branch;
    redir_pc   = evt_join ? abs_target(head_q, word) : rel_target(fpc, word);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_nop     <= 1'b0;
      out_two     <= 1'b0;
      out_instr   <= '0;
      out_opnd    <= '0;
      out_pc      <= '0;
      hold_q      <= 1'b0;
      head_q      <= '0;
      head_pc_q   <= '0;
      skip_pend_q <= 1'b0;
    end else begin
      out_valid <= evt_bubble || evt_join || skip_hit || evt_orphan ||
                   evt_branch || evt_single;
      out_nop   <= evt_bubble || skip_hit || evt_orphan;
      out_two   <= evt_join;
      out_instr <= evt_join ? head_q : ((evt_branch || evt_single) ? word : '0);
      out_opnd  <= evt_join ? {head_q[PAY_W-1:0], word[PAY_W-1:0]} : '0;
      out_pc    <= evt_join ? head_pc_q : fpc;
      if (evt_hold) begin
        hold_q    <= 1'b1;
        head_q    <= word;
        head_pc_q <= fpc;
      end else if (evt_join) begin
        hold_q    <= 1'b0;
      end
      skip_pend_q <= (skip_pend_q || skip_req) && !skip_hit;
    end
  end

  assert_head_silent_R4: assert property (@(posedge clk) disable iff (rst)
    evt_hold |=> !out_valid);

  assert_pair_done_R4: assert property (@(posedge clk) disable iff (rst)
    evt_join |=> out_valid && out_two && !out_nop);

  assert_lone_tail_R5: assert property (@(posedge clk) disable iff (rst)
    evt_orphan |=> out_valid && out_nop);

  assert_bubble_R8: assert property (@(posedge clk) disable iff (rst)
    redir |=> ##1 (out_valid && out_nop));

  assert_skip_nop_R9: assert property (@(posedge clk) disable iff (rst)
    skip_hit |=> out_valid && out_nop && !out_two);

endmodule

// File: rtl/insn_fetch_seq.sv
module insn_fetch_seq
  import fseq_pkg::*;
#(
  parameter int PC_W = 21,
  localparam int WA_W   = PC_W - 1,
  localparam int OPND_W = 2 * PAY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              skip_req,
  output logic [WA_W-1:0]   mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              out_valid,
  output logic              out_nop,
  output logic              out_two,
  output logic [WORD_W-1:0] out_instr,
  output logic [OPND_W-1:0] out_opnd,
  output logic [PC_W-1:0]   out_pc
);

  logic [PC_W-1:0] pc_q, fpc_q, redir_pc;
  logic            req_vld_q, flush_q, redir;
  wclass_e         cls;

  fseq_pc #(.PC_W(PC_W)) u_pc (
    .clk       (clk),
    .rst       (rst),
    .redir     (redir),
    .redir_pc  (redir_pc),
    .pc_q      (pc_q),
    .fpc_q     (fpc_q),
    .req_vld_q (req_vld_q),
    .flush_q   (flush_q)
  );

  fseq_decode u_dec (
    .word (mem_rdata),
    .cls  (cls)
  );

  fseq_join #(.PC_W(PC_W)) u_join (
    .clk       (clk),
    .rst       (rst),
    .req_vld   (req_vld_q),
    .flush     (flush_q),
    .fpc       (fpc_q),
    .word      (mem_rdata),
    .cls       (cls),
    .skip_req  (skip_req),
    .redir     (redir),
    .redir_pc  (redir_pc),
    .out_valid (out_valid),
    .out_nop   (out_nop),
    .out_two   (out_two),
    .out_instr (out_instr),
    .out_opnd  (out_opnd),
    .out_pc    (out_pc)
  );

  assign mem_addr = pc_q[PC_W-1:1];

  // R1: reset keeps the event output quiet.
  assert_quiet_R1: assert property (@(posedge clk) rst |=> !out_valid);

  // R2: every event address is even.
  assert_even_pc_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_pc[0]);

endmodule

// File: tb/insn_fetch_seq_bench.sv
module insn_fetch_seq_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PC_W = 21;
  localparam int NEV  = 80;
  localparam int NRE  = 25;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        skip_req = 1'b0;
  logic [19:0] mem_addr;
  logic [15:0] mem_rdata;
  logic        out_valid, out_nop, out_two;
  logic [15:0] out_instr;
  logic [23:0] out_opnd;
  logic [20:0] out_pc;

  int checks = 0;
  int fails  = 0;

  logic [15:0] prog [256];

  logic [20:0] e_pc  [NEV];
  logic        e_nop [NEV];
  logic        e_two [NEV];
  logic [15:0] e_ins [NEV];
  logic [23:0] e_opd [NEV];
  string       e_tag [NEV];
  int          nexp;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) mem_rdata <= prog[mem_addr[7:0]];

  insn_fetch_seq #(.PC_W(PC_W)) u_insn_fetch_seq (
    .clk(clk), .rst(rst), .skip_req(skip_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_nop(out_nop),
    .out_two(out_two), .out_instr(out_instr), .out_opnd(out_opnd),
    .out_pc(out_pc)
  );

  function automatic bit skip_after(input int p);
    return (p == 6) || (p == 18) || (p == 'h40);
  endfunction

  function automatic int wclass(input logic [15:0] w); // 0 single,1 head,2 tail,3 branch
    case (w[15:12])
      4'hF: return 2;
      4'hC: return 1;
      4'hE: return (w[11:10] == 2'b11) ? 1 : 0;
      4'hD: return w[11] ? 0 : 3;
      default: return 0;
    endcase
  endfunction

  task automatic add_ev(input int p, input bit nop, input logic [15:0] ins,
                        input bit two, input logic [23:0] opd, input string tag);
    if (nexp < NEV) begin
      e_pc[nexp] = 21'(p); e_nop[nexp] = nop; e_ins[nexp] = ins;
      e_two[nexp] = two; e_opd[nexp] = opd; e_tag[nexp] = tag;
      nexp++;
    end
  endtask

  // Walks the program image arithmetically to produce the expected events.
  task automatic build_model();
    int p, off;
    bit sk;
    logic [15:0] w, s;
    p = 0; sk = 0; nexp = 0;
    while (nexp < NEV) begin
      w = prog[(p >> 1) & 255];
      if (sk) begin
        add_ev(p, 1, 16'h0, 0, 24'h0, "R9"); sk = 0; p += 2;
      end else if (wclass(w) == 2) begin
        add_ev(p, 1, 16'h0, 0, 24'h0, "R5"); p += 2;
      end else if (wclass(w) == 1) begin
        s = prog[((p + 2) >> 1) & 255];
        sk = skip_after(p);
        if (w[15:8] inside {8'hEC, 8'hED, 8'hEF}) begin
          add_ev(p, 0, w, 1, {w[11:0], s[11:0]}, "R6");
          add_ev(p + 4, 1, 16'h0, 0, 24'h0, "R8");
          p = int'(s[11:0]) * 512 + int'(w[7:0]) * 2;
        end else begin
          add_ev(p, 0, w, 1, {w[11:0], s[11:0]}, "R4");
          p += 4;
        end
      end else if (wclass(w) == 3) begin
        off = w[10] ? int'(w[10:0]) - 2048 : int'(w[10:0]);
        add_ev(p, 0, w, 0, 24'h0, "R7");
        add_ev(p + 2, 1, 16'h0, 0, 24'h0, "R8");
        sk = skip_after(p);
        p = p + 2 + 2 * off;
      end else begin
        add_ev(p, 0, w, 0, 24'h0, "R3");
        sk = skip_after(p);
        p += 2;
      end
    end
  endtask

  task automatic check_event(input int k);
    bit bad;
    checks++;
    bad = (out_pc !== e_pc[k]) || out_pc[0] || (out_nop !== e_nop[k]);
    if (!e_nop[k])
      bad = bad || (out_instr !== e_ins[k]) || (out_two !== e_two[k]) ||
            (out_opnd !== e_opd[k]);
    if (bad) begin
      fails++;
      $display("FAIL %s event %0d: pc=%h nop=%b ins=%h two=%b opnd=%h expected pc=%h nop=%b ins=%h two=%b opnd=%h",
               e_tag[k], k, out_pc, out_nop, out_instr, out_two, out_opnd,
               e_pc[k], e_nop[k], e_ins[k], e_two[k], e_opd[k]);
    end
  endtask

  task automatic check_bit(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_phase(input int n);
    int k, cyc;
    k = 0; cyc = 0;
    while (k < n && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (out_valid) begin
        check_event(k);
        skip_req = !out_nop && skip_after(int'(out_pc));
        k++;
      end else begin
        skip_req = 1'b0;
      end
    end
    @(negedge clk);
    skip_req = 1'b0;
    if (k < n) begin
      checks++; fails++;
      $display("FAIL R3 event stream stalled: actual %0d events expected %0d", k, n);
    end
  endtask

  task automatic reset_and_check();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_bit("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    check_bit("R1", "mem_addr in reset", 32'(mem_addr), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check_bit("R1", "out_valid first cycle", 32'(out_valid), 32'd0);
    check_bit("R2", "mem_addr after one step", 32'(mem_addr), 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
    prog['h00 >> 1] = 16'h0F55;
    prog['h02 >> 1] = 16'hC123;  // move 0x123 -> 0x456
    prog['h04 >> 1] = 16'hF456;
    prog['h06 >> 1] = 16'h6600;  // skip after this
    prog['h08 >> 1] = 16'hC001;  // skipped head
    prog['h0A >> 1] = 16'hF002;  // lone tail
    prog['h0C >> 1] = 16'hEE10;  // load pointer
    prog['h0E >> 1] = 16'hF0AB;
    prog['h10 >> 1] = 16'hF777;  // lone tail
    prog['h12 >> 1] = 16'h2400;  // skip after this
    prog['h14 >> 1] = 16'h1111;
    prog['h16 >> 1] = 16'hEF20;  // goto 0x40
    prog['h18 >> 1] = 16'hF000;
    prog['h1A >> 1] = 16'h0ABC;  // flushed
    prog['h40 >> 1] = 16'hD009;  // branch +9 -> 0x54, skip after
    prog['h42 >> 1] = 16'h0BAD;
    prog['h48 >> 1] = 16'hED30;  // call 0x60
    prog['h4A >> 1] = 16'hF000;
    prog['h54 >> 1] = 16'h7777;  // skipped via pending request
    prog['h56 >> 1] = 16'hD7F8;  // branch -8 -> 0x48
    prog['h60 >> 1] = 16'h3456;
    prog['h62 >> 1] = 16'hEF03;  // goto 0x000006
    prog['h64 >> 1] = 16'hF000;
    build_model();
    reset_and_check();
    run_phase(NEV);
    reset_and_check();
    run_phase(NRE);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL R3 watchdog expired: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule